// File: doc/BRIEF.md
# Four-Lane PHY Management Register Bank

This block is a small bank of vendor-specific management registers for a four-lane serial PHY. A management frame decoder sits in front of it and presents each access as an address, sixteen bits of write data, a write strobe and a read strobe. Read data is combinational from the address. The side effects of a read take place at the clock edge where the read strobe is high.

The bank holds three control fields that feed the analog front end: the receive equalizer boost, the transmit output amplitude, and a per-lane pre-emphasis enable. Their reset values come from the mode input, sampled while reset is low. A status word reports per-lane signal-detect and loss-of-signal conditions. Each condition is latched after a two-flop synchronizer, so a short event survives until software reads the word. A self-clearing command bit produces a fixed-length reset pulse for the datapath and leaves every register value unchanged.

Register map (5-bit address): 0x01 equalizer, 0x02 adjustment, 0x04 status, 0x08 soft reset. Every other address is undefined.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While rst_n is low, mode_sel picks the control defaults. With mode_sel=0 the defaults are boost 0x0, amplitude 0x5 and pre-emphasis 0x0. With mode_sel=1 they are boost 0xC, amplitude 0x3 and pre-emphasis 0xF. The test field is 0 in both modes.
- R2: The equalizer register (0x01) holds the boost in bits 3:0, where 0 means no boost and 0xF means maximum boost. Bits 15:4 read as zero and ignore writes. The value drives eq_coeff.
- R3: The adjustment register (0x02) holds the amplitude in bits 9:6 and the pre-emphasis enables in bits 5:2, with bit 5 for lane 3 and bit 2 for lane 0. Bits 1:0 always read 0, whatever is written. Bits 15:10 read as zero.
- R4: The status register (0x04) reads signal-detect for lanes 3..0 in bits 7:4 and loss-of-signal for lanes 3..0 in bits 3:0. Bits 15:8 read as zero. After reset it reads 0x00F0.
- R5: A signal-detect bit falls to 0 on any cycle where the lane's synchronized detect is low. It stays 0 until the status register is read, and returns to 1 after the read if detect is then high.
- R6: A loss-of-signal bit rises to 1 on any cycle where the lane's synchronized loss input is high. It stays 1 until the status register is read, and returns to 0 after the read if loss is then low.
- R7: An event that is present at the same edge as a status read stays latched after that read.
- R8: The raw lane inputs pass through two flops. A raw change driven before edge N is not visible after edge N+1 and is visible in the status register after edge N+2.
- R9: Writing 1 to bit 15 of the soft-reset register (0x08) drives dp_soft_rst high for exactly 8 cycles, starting after the write edge. Bit 15 reads 1 during that interval and 0 afterwards. A write while the pulse is active has no effect.
- R10: A soft reset leaves the equalizer, amplitude and pre-emphasis values unchanged.
- R11: Reads of undefined addresses return 0. Writes to undefined addresses and to the status register change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Default-profile select, sampled during reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (drives the clear-on-read side effects) |
| reg_rdata | output | 16 | Read data for reg_addr |
| sig_det_raw | input | 4 | Asynchronous per-lane signal-detect |
| los_raw | input | 4 | Asynchronous per-lane loss-of-signal |
| eq_coeff | output | 4 | Equalizer boost |
| amp_ctrl | output | 4 | Output amplitude |
| preemph_en | output | 4 | Per-lane pre-emphasis enable |
| dp_soft_rst | output | 1 | Datapath reset pulse, active high |

## Verification
The bound checker checks four things on every cycle:
- outside a status read, no latched bit recovers;
- after a read, each latch holds exactly the synchronized inputs of the read edge;
- the test field of the adjustment register stays clear;
- the soft-reset pulse is exactly eight cycles long and matches the readback bit.

Only the bench scenarios can show the following: the mode-dependent defaults, the two-cycle synchronizer latency seen at the port, the values that persist across a soft reset, and the fact that writes to undefined addresses and to the status register are ignored. A bench model of the status latch is also compared against random lane activity mixed with random reads.

// File: rtl/phy_mgmt_pkg.sv
// Shared types, address map and default profiles for the PHY management bank.
package phy_mgmt_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_EQ   = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_ADJ  = 5'h02;
    localparam logic [ADDR_W-1:0] ADR_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_SRST = 5'h08;

    localparam int SRST_BIT = 15;

    typedef struct packed {
        logic [3:0] boost;
        logic [3:0] amp;
        logic [3:0] pre;
    } ctrl_t;

    // Default control profile selected by the mode input.
    function automatic ctrl_t ctrl_default(input logic mode);
        ctrl_t c;
        if (mode) begin
            c.boost = 4'hC; c.amp = 4'h3; c.pre = 4'hF;
        end else begin
            c.boost = 4'h0; c.amp = 4'h5; c.pre = 4'h0;
        end
        return c;
    endfunction
endpackage

// File: rtl/phy_lane_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous lane flags.
// Assumes each bit is a level that may be sampled independently of the others.
module phy_lane_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the flags one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[s] <= {W{RST_VAL}};
                else if (s == 0)
                    stg[s] <= d;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/phy_status_latch.sv
// Per-lane event latches: signal-detect latches low, loss-of-signal latches high.
// A read restores each bit to its idle value, but an event at the same edge wins.
// Assumes the inputs are already synchronous to clk.
module phy_status_latch #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LANES-1:0] sd_in,
    input  logic [LANES-1:0] los_in,
    output logic [LANES-1:0] sd_q,
    output logic [LANES-1:0] los_q
);
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Latch-low detect flag, set back to 1 by a read.
            always_ff @(posedge clk) begin
                if (!rst_n) sd_q[l] <= 1'b1;
                else        sd_q[l] <= (clr | sd_q[l]) & sd_in[l];
            end
            // Latch-high loss flag, cleared by a read.
            always_ff @(posedge clk) begin
                if (!rst_n) los_q[l] <= 1'b0;
                else        los_q[l] <= (~clr & los_q[l]) | los_in[l];
            end
        end
    endgenerate
endmodule

// File: rtl/phy_srst_timer.sv
// Fixed-length pulse generator for the datapath soft reset.
// A start request while the pulse is running is ignored.
module phy_srst_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // Load the pulse length on a start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start && cnt == '0)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/phy_mgmt_regs.sv
// Management register bank for a four-lane PHY: control fields with
// mode-dependent defaults, a latched lane status word and a soft-reset command.
// Assumes one access per cycle; read data is combinational from reg_addr.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SRST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [LANES-1:0]  sig_det_raw,
    input  logic [LANES-1:0]  los_raw,
    output logic [3:0]        eq_coeff,
    output logic [3:0]        amp_ctrl,
    output logic [3:0]        preemph_en,
    output logic              dp_soft_rst
);
    localparam int STAT_PAD = REG_W - 2*LANES;

    ctrl_t            ctrl;
    logic [LANES-1:0] sd_sync, los_sync, sd_lat, los_lat;
    logic             stat_clr, srst_go, srst_busy;

    assign stat_clr = reg_rd && (reg_addr == ADR_STAT);
    assign srst_go  = reg_wr && (reg_addr == ADR_SRST) && reg_wdata[SRST_BIT];

    phy_lane_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sd_sync (
        .clk(clk), .rst_n(rst_n), .d(sig_det_raw), .q(sd_sync));

    phy_lane_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_los_sync (
        .clk(clk), .rst_n(rst_n), .d(los_raw), .q(los_sync));

    phy_status_latch #(.LANES(LANES)) u_latch (
        .clk(clk), .rst_n(rst_n), .clr(stat_clr),
        .sd_in(sd_sync), .los_in(los_sync), .sd_q(sd_lat), .los_q(los_lat));

    phy_srst_timer #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst_n(rst_n), .start(srst_go), .active(srst_busy));

    // Control fields: load mode defaults in reset, take decoded writes after.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= ctrl_default(mode_sel);
        else if (reg_wr) begin
            case (reg_addr)
                ADR_EQ:  ctrl.boost <= reg_wdata[3:0];
                ADR_ADJ: begin
                    ctrl.amp <= reg_wdata[9:6];
                    ctrl.pre <= reg_wdata[5:2];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer; undefined addresses return zero.
    always_comb begin
        case (reg_addr)
            ADR_EQ:   reg_rdata = {12'h000, ctrl.boost};
            ADR_ADJ:  reg_rdata = {6'b0, ctrl.amp, ctrl.pre, 2'b00};
            ADR_STAT: reg_rdata = {{STAT_PAD{1'b0}}, sd_lat, los_lat};
            ADR_SRST: reg_rdata = {srst_busy, 15'b0};
            default:  reg_rdata = '0;
        endcase
    end

    assign eq_coeff    = ctrl.boost;
    assign amp_ctrl    = ctrl.amp;
    assign preemph_en  = ctrl.pre;
    assign dp_soft_rst = srst_busy;
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
// Cycle-level checker for phy_mgmt_regs, attached through bind.
// Observes ports plus the synchronizer and latch outputs.
module phy_mgmt_regs_chk
    import phy_mgmt_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SRST_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              dp_soft_rst,
    input logic [LANES-1:0]  sd_sync,
    input logic [LANES-1:0]  los_sync,
    input logic [LANES-1:0]  sd_lat,
    input logic [LANES-1:0]  los_lat
);
    localparam int HW = $clog2(SRST_CYCLES + 2);
    logic [HW-1:0] hi_cnt;
    logic          rd_stat;

    assign rd_stat = reg_rd && (reg_addr == ADR_STAT);

    // Count consecutive cycles with the soft-reset pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n)           hi_cnt <= '0;
        else if (dp_soft_rst) hi_cnt <= hi_cnt + 1'b1;
        else                  hi_cnt <= '0;
    end

    // R3
    adj_test_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_ADJ) |-> (reg_rdata[1:0] == 2'b00));

    // R5
    sd_no_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((sd_lat | $past(sd_lat)) == $past(sd_lat)));

    // R6
    los_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((los_lat & $past(los_lat)) == $past(los_lat)));

    // R7
    read_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (los_lat == $past(los_sync) && sd_lat == $past(sd_sync)));

    // R9
    srst_not_too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_soft_rst |-> (hi_cnt < HW'(SRST_CYCLES)));

    // R9
    srst_exact_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_soft_rst) |-> (hi_cnt == HW'(SRST_CYCLES)));

    // R9
    srst_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_SRST) |-> (reg_rdata[SRST_BIT] == dp_soft_rst));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.LANES(LANES), .SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .dp_soft_rst(dp_soft_rst),
    .sd_sync(sd_sync), .los_sync(los_sync), .sd_lat(sd_lat), .los_lat(los_lat));

// File: tb/test_phy_mgmt_regs.sv
// Self-checking bench: directed corner cases plus seeded random lane activity.
module test_phy_mgmt_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic [3:0]  sig_det_raw = 4'hF;
    logic [3:0]  los_raw = 4'h0;
    logic [3:0]  eq_coeff, amp_ctrl, preemph_en;
    logic        dp_soft_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [4:0] A_EQ = 5'h01, A_ADJ = 5'h02, A_STAT = 5'h04, A_SRST = 5'h08;

    phy_mgmt_regs i_phy_mgmt_regs (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .sig_det_raw(sig_det_raw), .los_raw(los_raw), .eq_coeff(eq_coeff),
        .amp_ctrl(amp_ctrl), .preemph_en(preemph_en), .dp_soft_rst(dp_soft_rst));

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] adj_word(input logic [3:0] a, input logic [3:0] p);
        return {6'b0, a, p, 2'b00};
    endfunction

    // Register write: strobe held over one rising edge.
    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    endtask

    // Register read with side effects; returns the data seen before the edge.
    task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(posedge clk); @(negedge clk); reg_rd = 1'b0;
    endtask

    // Look at read data without strobing.
    task automatic peek(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk); rst_n = 1'b0; mode_sel = m;
        sig_det_raw = 4'hF; los_raw = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [3:0] m_s1sd, m_s2sd, m_s1los, m_s2los, m_sd, m_los, m_eq, m_amp, m_pre;
        void'($urandom(32'h00C0FFEE));

        // R1 / R4: defaults in mode 0
        do_reset(1'b0);
        peek(A_EQ, v);   chk("R1 eq mode0", v, 16'h0000);
        peek(A_ADJ, v);  chk("R1 adj mode0", v, adj_word(4'h5, 4'h0));
        peek(A_STAT, v); chk("R4 status reset", v, 16'h00F0);
        peek(A_SRST, v); chk("R9 srst idle", v, 16'h0000);
        // R1: defaults in mode 1
        do_reset(1'b1);
        peek(A_EQ, v);   chk("R1 eq mode1", v, 16'h000C);
        peek(A_ADJ, v);  chk("R1 adj mode1", v, adj_word(4'h3, 4'hF));
        chk("R1 outputs mode1", {4'h0, eq_coeff, amp_ctrl, preemph_en}, 16'h0C3F);

        // R2 / R3: writes with reserved bits set
        wr_reg(A_EQ, 16'hFFF7);
        peek(A_EQ, v); chk("R2 eq write", v, 16'h0007);
        chk("R2 eq_coeff", {12'h0, eq_coeff}, 16'h0007);
        wr_reg(A_ADJ, 16'hFFFF);
        peek(A_ADJ, v); chk("R3 adj all ones", v, 16'h03FC);
        wr_reg(A_ADJ, adj_word(4'hA, 4'h6) | 16'h0003);
        peek(A_ADJ, v); chk("R3 adj fields", v, adj_word(4'hA, 4'h6));
        chk("R3 outputs", {8'h0, amp_ctrl, preemph_en}, 16'h00A6);

        // R8: loss on lane 1, visible only after the second synchronizer edge
        @(negedge clk); los_raw = 4'b0010;
        @(posedge clk); @(posedge clk); @(negedge clk);
        peek(A_STAT, v); chk("R8 not yet visible", v, 16'h00F0);
        @(posedge clk); @(negedge clk);
        peek(A_STAT, v); chk("R8 visible", v, 16'h00F2);
        los_raw = 4'b0000;
        repeat (4) @(negedge clk);
        peek(A_STAT, v); chk("R6 los held", v, 16'h00F2);
        rd_reg(A_STAT, v); chk("R6 read value", v, 16'h00F2);
        peek(A_STAT, v); chk("R6 cleared by read", v, 16'h00F0);

        // R5: one-cycle detect drop on lane 2
        @(negedge clk); sig_det_raw = 4'b1011;
        @(negedge clk); sig_det_raw = 4'b1111;
        repeat (4) @(negedge clk);
        peek(A_STAT, v); chk("R5 sd latched low", v, 16'h00B0);
        rd_reg(A_STAT, v); chk("R5 read value", v, 16'h00B0);
        peek(A_STAT, v); chk("R5 restored by read", v, 16'h00F0);

        // R7: loss pulse on lane 0 arrives at the same edge as a read
        @(negedge clk); los_raw = 4'b0001;
        @(posedge clk); @(negedge clk); los_raw = 4'b0000;
        @(posedge clk); @(negedge clk); reg_addr = A_STAT; reg_rd = 1'b1;
        #1 chk("R7 read before event", reg_rdata, 16'h00F0);
        @(posedge clk); @(negedge clk); reg_rd = 1'b0;
        peek(A_STAT, v); chk("R7 event kept", v, 16'h00F1);
        rd_reg(A_STAT, v);

        // R9 / R10: soft-reset pulse length and retention
        wr_reg(A_SRST, 16'h8000);
        for (int i = 0; i < 10; i++) begin
            peek(A_SRST, v);
            chk($sformatf("R9 pulse cycle %0d", i), {v[15], 14'h0, dp_soft_rst},
                (i < 8) ? 16'h8001 : 16'h0000);
            if (i == 2) begin
                reg_wdata = 16'h8000; reg_wr = 1'b1;
                @(posedge clk); @(negedge clk); reg_wr = 1'b0;
            end else begin
                @(posedge clk); @(negedge clk);
            end
        end
        peek(A_EQ, v);  chk("R10 eq kept", v, 16'h0007);
        peek(A_ADJ, v); chk("R10 adj kept", v, adj_word(4'hA, 4'h6));

        // R11: undefined addresses and status writes
        wr_reg(5'h1F, 16'hFFFF); wr_reg(5'h00, 16'hFFFF); wr_reg(A_STAT, 16'h0000);
        peek(5'h1F, v); chk("R11 undefined read", v, 16'h0000);
        peek(5'h03, v); chk("R11 undefined read 2", v, 16'h0000);
        peek(A_STAT, v); chk("R11 status not writable", v, 16'h00F0);
        peek(A_EQ, v);  chk("R11 eq untouched", v, 16'h0007);
        peek(A_ADJ, v); chk("R11 adj untouched", v, adj_word(4'hA, 4'h6));

        // R5 R6 R7 R2 R3: random lane activity, reads and writes against a model
        do_reset(1'b0);
        m_s1sd = 4'hF; m_s2sd = 4'hF; m_s1los = 4'h0; m_s2los = 4'h0;
        m_sd = 4'hF; m_los = 4'h0; m_eq = 4'h0; m_amp = 4'h5; m_pre = 4'h0;
        for (int c = 0; c < 600; c++) begin
            int op;
            logic clr;
            logic [15:0] wd;
            sig_det_raw = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            los_raw     = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            op = $urandom % 6;
            wd = 16'($urandom);
            reg_rd = 1'b0; reg_wr = 1'b0;
            case (op)
                0, 1: begin reg_addr = A_STAT; reg_rd = 1'b1; end
                2: begin reg_addr = A_EQ; reg_wr = 1'b1; reg_wdata = wd; end
                3: begin reg_addr = A_ADJ; reg_wr = 1'b1; reg_wdata = wd; end
                4: begin reg_addr = A_EQ; reg_rd = 1'b1; end
                default: begin reg_addr = A_ADJ; reg_rd = 1'b1; end
            endcase
            #1;
            if (op <= 1) chk("R5 R6 random status", reg_rdata, {8'h0, m_sd, m_los});
            if (op == 4) chk("R2 random eq", reg_rdata, {12'h0, m_eq});
            if (op == 5) chk("R3 random adj", reg_rdata, adj_word(m_amp, m_pre));
            clr = (op <= 1);
            @(posedge clk);
            m_sd  = (clr ? 4'hF : m_sd) & m_s2sd;
            m_los = (clr ? 4'h0 : m_los) | m_s2los;
            m_s2sd = m_s1sd; m_s1sd = sig_det_raw;
            m_s2los = m_s1los; m_s1los = los_raw;
            if (op == 2) m_eq = wd[3:0];
            if (op == 3) begin m_amp = wd[9:6]; m_pre = wd[5:2]; end
            @(negedge clk);
        end
        reg_rd = 1'b0; reg_wr = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule